// File: doc/BRIEF.md
# Disk sector address sequencer

This block converts a disk sector request, given as cylinder, head, sector number (counted from 1) and size code, into a byte offset within a flat disk image. The image is laid out for a two-headed geometry: every track holds the number of sectors given by the request's end-of-track value. The block also produces the sector address that follows the one requested, which the controller reports at the end of a transfer. It moves no data, does not check the medium, and has no multitrack mode.

A request is accepted through a valid/ready handshake. `req_ready` is high while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and the request fields are sampled on that edge. While a lawful request is being computed, `req_ready` stays low. An upstream source holds its request, with `req_valid` high, until the cycle in which `req_ready` is high. There is no queue.

The offset is computed by a serial shift-and-add engine that walks the bits of the end-of-track value. The results appear together with a one-cycle `done` pulse. A request with sector number 0, or with a size code above 5, is rejected at once: it raises `err` and produces no offset.

Top module: `disk_addr_seq`

## Requirements
- R1: During and directly after reset: `done`=0, `err`=0, `offset`=0, and `req_ready`=1.
- R2: A request is accepted on an edge with `req_valid` and `req_ready` both high. After a lawful request is accepted, `req_ready` is 0 until `done` rises. `req_ready` is 1 again in the cycle in which `done` is 1.
- R3: For a lawful request, `offset` = ((2·C + H)·EOT + (R − 1)) · 2^(7+N), reduced modulo 2^24. This equals C·(bytes per cylinder) + H·(bytes per track) + (R − 1)·(sector size).
- R4: For a lawful request, `sec_bytes` = 128 · 2^N, for N from 0 to 5.
- R5: The reported sector is R + 1. If R + 1 is greater than EOT, the reported sector is 1 instead.
- R6: When the sector wraps and H = 1, the reported head is 0 and the reported cylinder is C + 1 (mod 256). When the sector wraps and H = 0, the reported head is 0 and the reported cylinder is C.
- R7: When the sector does not wrap, the reported cylinder and head equal C and H. The reported size code always equals N.
- R8: For a lawful request, `done` is high for exactly one cycle. It is seen 9 clock edges after the accepting edge, which is the sector-field width plus one.
- R9: A request with R = 0 or N > 5 gives `done`=1 and `err`=1 in the cycle after the accepting edge. In that case `offset`=0, `sec_bytes`=0, and the reported C, H, R and N equal the request fields.
- R10: `err` is 0 on the `done` of every lawful request, including one that follows a rejected request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_cyl | input | 8 | Cylinder C |
| req_head | input | 1 | Head H |
| req_sec | input | 8 | Sector R, counted from 1 |
| req_eot | input | 8 | Last sector number on a track |
| req_size | input | 3 | Size code N |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Request rejected (with done) |
| offset | output | 24 | Byte offset into the image |
| sec_bytes | output | 13 | Sector byte count |
| nxt_cyl | output | 8 | Reported cylinder |
| nxt_head | output | 1 | Reported head |
| nxt_sec | output | 8 | Reported sector |
| nxt_size | output | 3 | Reported size code |

## Verification
The bench sweeps every size code from 0 to 7. It combines them with cylinders 0, 1, 40 and 255, both heads, sectors 0, 1, 2 and EOT, and EOT values 1, 9 and 26, and computes each expected offset and next address arithmetically. Several mistakes show up in this sweep:
- Dropping the −1 on the sector number would shift every offset by one sector.
- Advancing the cylinder when the wrap happens on head 0 would show up on the R = EOT cases.
- Missing the mod-256 carry at cylinder 255 would also show up.
- Mixing up bytes per track with bytes per cylinder would double or halve the cylinder term.

Size codes 6 and 7 and sector 0 must come back at once, with err set and the request echoed. A design that computed through them would give a late `done` and a non-zero offset. EOT = 1 forces a wrap on every sector. Each request also checks the latency of `done` and that `req_ready` stays low while the engine runs.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_CALC = 1'b1} dseq_state_t;

  // True when a request can be turned into an offset.
  function automatic logic req_lawful(input logic sec_zero, input logic size_big);
    return !(sec_zero || size_big);
  endfunction
endpackage

// File: rtl/dseq_mul.sv
// Serial shift-and-add multiplier: one multiplier bit per clock.
module dseq_mul #(
  parameter int MW = 9,
  parameter int SW = 8,
  localparam int PW = MW + SW,
  localparam int CNTW = (SW > 1) ? $clog2(SW) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [MW-1:0] mcand,
  input  logic [SW-1:0] mplier,
  output logic          fin,
  output logic [PW-1:0] prod
);
  logic            run_q;
  logic [CNTW-1:0] cnt_q;
  logic [PW-1:0]   mc_q;
  logic [SW-1:0]   mp_q;
  logic [PW-1:0]   acc_q;
  logic            fin_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      mc_q  <= '0;
      mp_q  <= '0;
      acc_q <= '0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (start) begin
        run_q <= 1'b1;
        cnt_q <= '0;
        mc_q  <= {{SW{1'b0}}, mcand};
        mp_q  <= mplier;
        acc_q <= '0;
      end else if (run_q) begin
        if (mp_q[0]) acc_q <= acc_q + mc_q;
        mc_q  <= mc_q << 1;
        mp_q  <= mp_q >> 1;
        cnt_q <= cnt_q + CNTW'(1);
        if (cnt_q == CNTW'(SW - 1)) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign fin  = fin_q;
  assign prod = acc_q;

  // R8: the product strobe only follows a running engine and lasts one cycle
  a_r8_fin_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> $past(run_q));
  a_r8_fin_single: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |=> !fin_q);
  // R2: a new start never lands on a running engine
  a_r2_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> !start);
endmodule

// File: rtl/dseq_next.sv
// Next sector address after one completed transfer.
module dseq_next #(
  parameter int CW = 8,
  parameter int SW = 8
) (
  input  logic [CW-1:0] cyl,
  input  logic          head,
  input  logic [SW-1:0] sec,
  input  logic [SW-1:0] eot,
  output logic [CW-1:0] n_cyl,
  output logic          n_head,
  output logic [SW-1:0] n_sec
);
  logic [SW:0] s_inc;
  logic        wrap;

  always_comb begin
    s_inc  = {1'b0, sec} + (SW+1)'(1);
    wrap   = s_inc > {1'b0, eot};
    n_sec  = wrap ? SW'(1) : s_inc[SW-1:0];
    n_cyl  = (wrap && head) ? cyl + CW'(1) : cyl;
    n_head = head && !wrap;
  end
endmodule

// File: rtl/dseq_scale.sv
// Sector-size scaling: places the linear sector index at byte granularity.
module dseq_scale #(
  parameter int PW = 17,
  parameter int SW = 8,
  parameter int NW = 3,
  parameter int OW = 24,
  parameter int BASE_SH = 7,
  parameter int MAX_N = 5,
  localparam int BYW = BASE_SH + MAX_N + 1,
  localparam int SUMW = PW + 1,
  localparam int SAW = $clog2(BASE_SH + MAX_N + 1),
  localparam int SHW = SUMW + BASE_SH + MAX_N
) (
  input  logic [PW-1:0]  track_idx,
  input  logic [SW-1:0]  sec,
  input  logic [NW-1:0]  size,
  output logic [OW-1:0]  byte_off,
  output logic [BYW-1:0] bytes
);
  logic [SUMW-1:0] lin;
  logic [SAW-1:0]  shamt;
  logic [SHW-1:0]  wide;

  always_comb begin
    lin      = {1'b0, track_idx} + {{(SUMW-SW){1'b0}}, sec - SW'(1)};
    shamt    = SAW'(BASE_SH) + SAW'(size);
    wide     = SHW'(lin) << shamt;
    byte_off = wide[OW-1:0];
    bytes    = BYW'(1) << shamt;
  end
endmodule

// File: rtl/disk_addr_seq.sv
module disk_addr_seq #(
  parameter int CW = 8,
  parameter int SW = 8,
  parameter int NW = 3,
  parameter int OW = 24,
  parameter int BASE_SH = 7,
  parameter int MAX_N = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [CW-1:0]            req_cyl,
  input  logic                     req_head,
  input  logic [SW-1:0]            req_sec,
  input  logic [SW-1:0]            req_eot,
  input  logic [NW-1:0]            req_size,
  output logic                     done,
  output logic                     err,
  output logic [OW-1:0]            offset,
  output logic [BASE_SH+MAX_N:0]   sec_bytes,
  output logic [CW-1:0]            nxt_cyl,
  output logic                     nxt_head,
  output logic [SW-1:0]            nxt_sec,
  output logic [NW-1:0]            nxt_size
);
  import dseq_pkg::*;

  localparam int MW  = CW + 1;
  localparam int PW  = MW + SW;
  localparam int BYW = BASE_SH + MAX_N + 1;

  dseq_state_t   state_q;
  logic [CW-1:0] cyl_q;
  logic          head_q;
  logic [SW-1:0] sec_q;
  logic [SW-1:0] eot_q;
  logic [NW-1:0] size_q;

  logic          accept, lawful, mul_fin;
  logic [PW-1:0] prod;
  logic [OW-1:0] off_c;
  logic [BYW-1:0] bytes_c;
  logic [CW-1:0] ncyl_c;
  logic          nhead_c;
  logic [SW-1:0] nsec_c;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign lawful    = req_lawful(req_sec == '0, req_size > NW'(MAX_N));

  // {C,H} as one number is 2C+H: the track index before scaling by EOT
  dseq_mul #(.MW(MW), .SW(SW)) u_mul (
    .clk(clk), .rst_n(rst_n), .start(accept && lawful),
    .mcand({req_cyl, req_head}), .mplier(req_eot),
    .fin(mul_fin), .prod(prod)
  );

  dseq_scale #(.PW(PW), .SW(SW), .NW(NW), .OW(OW), .BASE_SH(BASE_SH), .MAX_N(MAX_N)) u_scale (
    .track_idx(prod), .sec(sec_q), .size(size_q),
    .byte_off(off_c), .bytes(bytes_c)
  );

  dseq_next #(.CW(CW), .SW(SW)) u_next (
    .cyl(cyl_q), .head(head_q), .sec(sec_q), .eot(eot_q),
    .n_cyl(ncyl_c), .n_head(nhead_c), .n_sec(nsec_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cyl_q     <= '0;
      head_q    <= 1'b0;
      sec_q     <= '0;
      eot_q     <= '0;
      size_q    <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      offset    <= '0;
      sec_bytes <= '0;
      nxt_cyl   <= '0;
      nxt_head  <= 1'b0;
      nxt_sec   <= '0;
      nxt_size  <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        cyl_q  <= req_cyl;
        head_q <= req_head;
        sec_q  <= req_sec;
        eot_q  <= req_eot;
        size_q <= req_size;
        if (lawful) begin
          state_q <= ST_CALC;
        end else begin
          done      <= 1'b1;
          err       <= 1'b1;
          offset    <= '0;
          sec_bytes <= '0;
          nxt_cyl   <= req_cyl;
          nxt_head  <= req_head;
          nxt_sec   <= req_sec;
          nxt_size  <= req_size;
        end
      end else if (state_q == ST_CALC && mul_fin) begin
        state_q   <= ST_IDLE;
        done      <= 1'b1;
        err       <= 1'b0;
        offset    <= off_c;
        sec_bytes <= bytes_c;
        nxt_cyl   <= ncyl_c;
        nxt_head  <= nhead_c;
        nxt_sec   <= nsec_c;
        nxt_size  <= size_q;
      end
    end
  end

  // R2: a lawful request takes the block out of idle
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_sec != '0 && req_size <= NW'(MAX_N)) |=> !req_ready);
  // R8: lawful results are single pulses
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |=> !(done && !err));
  // R9: a rejected request yields no offset
  a_r9_err_no_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (offset == '0 && sec_bytes == '0));
  // R5: reported sector stays inside 1..EOT after a lawful request
  a_r5_sec_range: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (nxt_sec != '0 && nxt_sec <= eot_q));
  // R6: head 1 is only reported when no cylinder advance happened
  a_r6_head_keeps_cyl: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && nxt_head) |-> (nxt_cyl == cyl_q));
  // R7: size code comes back unchanged
  a_r7_size_echo: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (nxt_size == size_q));
endmodule

// File: tb/disk_addr_seq_test.sv
module disk_addr_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_cyl = '0;
  logic        req_head = 1'b0;
  logic [7:0]  req_sec = '0;
  logic [7:0]  req_eot = '0;
  logic [2:0]  req_size = '0;
  logic        done, err;
  logic [23:0] offset;
  logic [12:0] sec_bytes;
  logic [7:0]  nxt_cyl;
  logic        nxt_head;
  logic [7:0]  nxt_sec;
  logic [2:0]  nxt_size;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  disk_addr_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cyl(req_cyl), .req_head(req_head), .req_sec(req_sec), .req_eot(req_eot),
    .req_size(req_size), .done(done), .err(err), .offset(offset),
    .sec_bytes(sec_bytes), .nxt_cyl(nxt_cyl), .nxt_head(nxt_head),
    .nxt_sec(nxt_sec), .nxt_size(nxt_size)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_req(input int c, input int h, input int r, input int eot, input int n);
    int lat;
    longint ss, bpt, eoff;
    int ecyl, ehead, esec;
    bit bad;
    @(negedge clk);
    req_cyl = 8'(c); req_head = h[0]; req_sec = 8'(r);
    req_eot = 8'(eot); req_size = 3'(n); req_valid = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    lat = 0;
    bad = (r == 0) || (n > 5);
    if (!bad) chk("R2 ready low while busy", longint'(req_ready), 0);
    while (!done && lat < 40) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    if (bad) begin
      chk("R9 reject latency", lat, 0);
      chk("R9 err", longint'(err), 1);
      chk("R9 offset", longint'(offset), 0);
      chk("R9 bytes", longint'(sec_bytes), 0);
      chk("R9 echo cyl", longint'(nxt_cyl), c);
      chk("R9 echo head", longint'(nxt_head), h);
      chk("R9 echo sec", longint'(nxt_sec), r);
      chk("R9 echo size", longint'(nxt_size), n);
    end else begin
      ss   = longint'(128) << n;
      bpt  = ss * eot;
      eoff = (longint'(c) * 2 * bpt + longint'(h) * bpt + longint'(r - 1) * ss) % (longint'(1) << 24);
      if (r + 1 > eot) begin
        esec = 1; ehead = 0;
        ecyl = (h == 1) ? ((c + 1) % 256) : c;
      end else begin
        esec = r + 1; ehead = h; ecyl = c;
      end
      chk("R8 latency", lat, 9);
      chk("R10 err clear", longint'(err), 0);
      chk("R3 offset", longint'(offset), eoff);
      chk("R4 bytes", longint'(sec_bytes), ss);
      chk("R5 next sec", longint'(nxt_sec), esec);
      chk("R6 next cyl", longint'(nxt_cyl), ecyl);
      chk("R6 R7 next head", longint'(nxt_head), ehead);
      chk("R7 size echo", longint'(nxt_size), n);
      chk("R2 ready back", longint'(req_ready), 1);
      @(posedge clk); @(negedge clk);
      chk("R8 done single", longint'(done), 0);
    end
  endtask

  initial begin
    int cyls[4] = '{0, 1, 40, 255};
    int eots[3] = '{1, 9, 26};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 done in reset", longint'(done), 0);
    chk("R1 err in reset", longint'(err), 0);
    chk("R1 offset in reset", longint'(offset), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", longint'(req_ready), 1);
    chk("R1 done after reset", longint'(done), 0);
    foreach (eots[e]) begin
      foreach (cyls[ci]) begin
        for (int h = 0; h < 2; h++) begin
          for (int n = 0; n < 8; n++) begin
            run_req(cyls[ci], h, 0, eots[e], n);
            run_req(cyls[ci], h, 1, eots[e], n);
            run_req(cyls[ci], h, 2, eots[e], n);
            run_req(cyls[ci], h, eots[e], eots[e], n);
          end
        end
      end
    end
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule